// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets each processor in a small multiprocessor cluster interrupt any other processor and hand it a 16-bit message in the same step. Every processor slot has a control word and a status word in a compact register window. Each slot also drives its own level interrupt line.

A processor sends a message by writing its own control word. The write carries a generate flag, a destination slot index and a payload. The destination's status word then records that a message is pending, which slot sent it, and the payload, and the destination's interrupt line goes high. The receiver reads its status word to collect the message. It then writes its own control word with the acknowledge flag set, which clears the pending flag and drops its line.

The bus is a plain synchronous register port: address, write enable, write data, and read data that is registered one cycle after the address. The number of active slots is a parameter. It may not exceed the size of the window.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset, every control and status word reads as zero and every interrupt output is low. This also holds when reset is applied again while a message is pending.
- R2: Bus address bits [1:0] are ignored. Bit 2 selects the control word (0) or the status word (1), and bits from 3 upward select the slot. Read data is registered: `rd_data` changes only at a clock edge, and it shows the word addressed during the cycle before that edge.
- R3: A write to a slot's control word stores the complete 32-bit written value, and a later read of that control word returns that value.
- R4: A control write with bit 30 (generate) set loads the status word of the slot named in bits 29:16 as follows: bit 30 = 1 (pending), bits 29:16 = index of the writing slot, bits 15:0 = bits 15:0 of the write. All other status bits are 0. The destination's interrupt output is high from the next cycle.
- R5: A control write with bit 31 (acknowledge) set clears the pending bit of the writer's own status word and drives the writer's interrupt output low from the next cycle. The sender and payload fields of that status word are kept.
- R6: When one write sets both generate and acknowledge, the generate takes effect first and the acknowledge second. A slot that signals itself and acknowledges in the same write ends with pending clear and its line low, with the new sender and payload recorded. A slot that signals another slot and acknowledges in the same write raises the other slot's line and clears its own.
- R7: A generate whose destination index is at or above the active slot count changes no status word and no interrupt output. The control word is still stored.
- R8: Writes to a status word change no register and no interrupt output.
- R9: An interrupt output stays high until its own slot acknowledges. A second generate to a slot that is already pending overwrites that slot's sender and payload fields.
- R10: Writes to a slot at or above the active slot count are ignored, and reads from such a slot return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address in the register window |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | NUM_PROCS (3) | One level interrupt line per active slot |

## Verification
The assertions assume that the bus performs at most one access per cycle and that `bus_addr`, `bus_we` and `bus_wdata` are known whenever reset is released. They also assume that the enable is a single-cycle pulse for each write. The bench drives the bus at the falling edge and clears the enable right after each rising edge, so every write lands in exactly one cycle. It keeps every address inside the 32-byte window and includes the unpopulated slot, so that rejected writes and rejected generates are still legal bus traffic.

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int MAX_PROCS = 4,
  parameter int NUM_PROCS = 3,
  localparam int SLOT_W   = (MAX_PROCS > 1) ? $clog2(MAX_PROCS) : 1,
  localparam int ADDR_W   = SLOT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic [NUM_PROCS-1:0] irq_o
);

  if (NUM_PROCS > MAX_PROCS || NUM_PROCS < 1) begin : g_bad_cfg
    $error("ipi_mailbox: NUM_PROCS out of range");
  end

  logic [31:0] ctrl_q [NUM_PROCS];
  logic [13:0] src_q  [NUM_PROCS];
  logic [15:0] pay_q  [NUM_PROCS];
  logic [NUM_PROCS-1:0] pend_q;

  wire [SLOT_W-1:0] slot    = bus_addr[ADDR_W-1:3];
  wire              slot_ok = 32'(slot) < NUM_PROCS;
  wire              sel_st  = bus_addr[2];
  wire              wr_ctrl = bus_we && !sel_st && slot_ok;
  wire [13:0]       dst     = bus_wdata[29:16];
  wire              do_gen  = wr_ctrl && bus_wdata[30] && (32'(dst) < NUM_PROCS);
  wire              do_ack  = wr_ctrl && bus_wdata[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NUM_PROCS; i++) begin
        ctrl_q[i] <= '0;
        src_q[i]  <= '0;
        pay_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PROCS; i++) begin
        if (wr_ctrl && slot == SLOT_W'(i)) ctrl_q[i] <= bus_wdata;
        if (do_gen && dst == 14'(i)) begin
          pend_q[i] <= 1'b1;
          src_q[i]  <= 14'(slot);
          pay_q[i]  <= bus_wdata[15:0];
        end
        if (do_ack && slot == SLOT_W'(i)) pend_q[i] <= 1'b0;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PROCS; i++)
      if (slot == SLOT_W'(i))
        rd_mux = sel_st ? {1'b0, pend_q[i], src_q[i], pay_q[i]} : ctrl_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_mux;
  end

  assign irq_o = pend_q;

  p_status_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && sel_st |=> $stable(irq_o));

  for (genvar g = 0; g < NUM_PROCS; g++) begin : g_chk
    wire own_ack = wr_ctrl && bus_wdata[31] && slot == SLOT_W'(g);
    wire gen_me  = wr_ctrl && bus_wdata[30] && dst == 14'(g);

    p_ack_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      own_ack |=> !irq_o[g]);

    p_gen_raises_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gen_me && !own_ack |=> irq_o[g]);

    p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] && !own_ack |=> irq_o[g]);

    p_no_spurious_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o[g] && !gen_me |=> !irq_o[g]);
  end

endmodule

// File: tb/ipi_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipi_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic [2:0]  irq_o;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ipi_mailbox #(.MAX_PROCS(4), .NUM_PROCS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_o(irq_o));

  // {we, addr, wdata, expected read, expected irq, requirement}
  localparam int NV = 24;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 5'h04, 32'h0,         32'h0000_0000, 3'b000, 4'd1},  // R1
    {1'b1, 5'h00, 32'h4001_ABCD, 32'h0,         3'b010, 4'd4},  // R4
    {1'b0, 5'h0C, 32'h0,         32'h4000_ABCD, 3'b010, 4'd4},  // R4
    {1'b0, 5'h00, 32'h0,         32'h4001_ABCD, 3'b010, 4'd3},  // R3
    {1'b1, 5'h10, 32'h4001_1234, 32'h0,         3'b010, 4'd9},  // R9
    {1'b0, 5'h0C, 32'h0,         32'h4002_1234, 3'b010, 4'd9},  // R9
    {1'b1, 5'h0C, 32'hFFFF_FFFF, 32'h0,         3'b010, 4'd8},  // R8
    {1'b0, 5'h0C, 32'h0,         32'h4002_1234, 3'b010, 4'd8},  // R8
    {1'b1, 5'h08, 32'h8000_0000, 32'h0,         3'b000, 4'd5},  // R5
    {1'b0, 5'h0C, 32'h0,         32'h0002_1234, 3'b000, 4'd5},  // R5
    {1'b0, 5'h08, 32'h0,         32'h8000_0000, 3'b000, 4'd3},  // R3
    {1'b1, 5'h00, 32'h4003_5555, 32'h0,         3'b000, 4'd7},  // R7
    {1'b0, 5'h00, 32'h0,         32'h4003_5555, 3'b000, 4'd7},  // R7
    {1'b1, 5'h10, 32'hC001_0777, 32'h0,         3'b010, 4'd6},  // R6
    {1'b0, 5'h0C, 32'h0,         32'h4002_0777, 3'b010, 4'd6},  // R6
    {1'b1, 5'h08, 32'hC001_0099, 32'h0,         3'b000, 4'd6},  // R6
    {1'b0, 5'h0C, 32'h0,         32'h0001_0099, 3'b000, 4'd6},  // R6
    {1'b1, 5'h18, 32'h4000_0001, 32'h0,         3'b000, 4'd10}, // R10
    {1'b0, 5'h18, 32'h0,         32'h0000_0000, 3'b000, 4'd10}, // R10
    {1'b0, 5'h04, 32'h0,         32'h0000_0000, 3'b000, 4'd10}, // R10
    {1'b1, 5'h08, 32'h4002_BEEF, 32'h0,         3'b100, 4'd4},  // R4
    {1'b0, 5'h14, 32'h0,         32'h4001_BEEF, 3'b100, 4'd4},  // R4
    {1'b1, 5'h12, 32'h8000_0000, 32'h0,         3'b000, 4'd2},  // R2
    {1'b0, 5'h16, 32'h0,         32'h0001_BEEF, 3'b000, 4'd2}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 irq in reset", {29'd0, irq_o}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [76:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[3:0], k);
      op(v[76], v[75:71], v[70:39]);
      if (!v[76]) chk({tag, " rd"}, rd_data, v[38:7]);
      chk({tag, " irq"}, {29'd0, irq_o}, {29'd0, v[6:4]});
    end

    // R2: read data holds until the next edge, then shows the new address
    op(1'b0, 5'h0C, 32'h0);
    chk("R2 read slot1 status", rd_data, 32'h0001_0099);
    @(negedge clk) bus_addr = 5'h00;
    #1 chk("R2 no combinational path", rd_data, 32'h0001_0099);
    @(posedge clk) #1 chk("R2 registered update", rd_data, 32'h4003_5555);

    // R1: reset while a message is pending
    op(1'b1, 5'h00, 32'h4002_0001);
    chk("R1 pre-reset irq", {29'd0, irq_o}, 32'd4);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk) #1 chk("R1 irq cleared", {29'd0, irq_o}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    op(1'b0, 5'h14, 32'h0);
    chk("R1 status cleared", rd_data, 32'h0);
    op(1'b0, 5'h00, 32'h0);
    chk("R1 control cleared", rd_data, 32'h0);

    finish_run();
  end
endmodule